// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block sequences reads from an asynchronous static memory that supports page-mode bursts. A client offers one read at a time on a request/address/ready handshake. The block drives an active-low chip-select, an active-low read strobe and the memory address. It samples the 32-bit data bus at the end of each access and returns the word with a single-cycle valid pulse.

A page is an aligned group of 4, 8, 16 or 32 bytes. When page mode is enabled, the block compares each new address with the page opened by the first access of the current burst. The first access to a page lasts the long programmed count. Each following access to the same page lasts the short count, and both strobes stay low between beats. A request to another page, or no request at all, ends the burst with at least one idle strobe cycle. A page miss then reopens the bus with a long access. When page mode is off, every read is a separate long access.

Top module: `page_rd_ctrl`

## Requirements
- R1: With page_en_i low, every read is a first access lasting max(first_pulse_i,1) cycles, and the strobes are high for at least one cycle between any two reads.
- R2: The first access of a burst keeps both strobes low for exactly max(first_pulse_i,1) cycles. Strobes go low in the cycle after the clock edge at which the request is accepted.
- R3: With page mode on, a request accepted in the last cycle of an access whose address lies in the open page keeps the strobes low with no high cycle in between. It lasts max(next_pulse_i,1) cycles.
- R4: page_size_i encodes 0=4, 1=8, 2=16, 3=32 bytes. Two addresses share a page when they agree in all bits from bit 2+page_size_i upward. A request to a different page ends the burst with exactly one high strobe cycle, followed by a first access.
- R5: dev_width_i encodes 0=8-bit, 1=16-bit, 2 or 3=32-bit. mem_addr_o equals the accepted address with bit 0 forced to zero for 16-bit devices and bits [1:0] forced to zero for 32-bit devices. It is stable for the whole access.
- R6: rdata_o takes the value of mem_data_i from the last strobe-low cycle of each access. rvalid_o is high for one cycle per access, in the cycle that follows that last cycle.
- R7: If no request is present in the last cycle of an access, both strobes go high, the open page is dropped, and the next read is a first access even when it is in the same page.
- R8: A pulse count of zero behaves as a count of one.
- R9: A request is taken at a clock edge where req_i and rdy_o are both high. rdy_o is high when idle, and during an access it is high only in the last cycle when the presented address hits the open page in page mode.
- R10: After reset, both strobes are high, rvalid_o is low and rdy_o is high.
- R11: mem_cs_no and mem_rd_no carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | 26 | Byte address of the request |
| rdy_o | output | 1 | Request is taken at this edge when req_i is high |
| page_en_i | input | 1 | Enables page-mode bursts |
| page_size_i | input | 2 | Page size: 0=4, 1=8, 2=16, 3=32 bytes |
| dev_width_i | input | 2 | Device width: 0=8, 1=16, 2/3=32 bits |
| first_pulse_i | input | 6 | Cycles of a first access in a page |
| next_pulse_i | input | 6 | Cycles of a later access within the page |
| mem_cs_no | output | 1 | Chip-select, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_addr_o | output | 26 | Memory address |
| mem_data_i | input | 32 | Memory data bus |
| rdata_o | output | 32 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse marking new rdata_o |

## Verification
The hardest case to reach is the last cycle of an access. In that single cycle, a waiting request decides between continuing the burst with no strobe gap, taking a one-cycle gap before a new first access, or closing the page. The bench keeps a request waiting on the handshake as soon as the previous one is accepted, so the hit-or-miss decision lands in that cycle. It uses address sequences that cross page boundaries at each page size and device width. A per-cycle log of the strobes, address and valid pulse is compared against a trace that the bench builds from the requirements.

// File: rtl/page_rd_pkg.sv
`timescale 1ns/1ps
package page_rd_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } rd_state_e;
endpackage

// File: rtl/page_match.sv
`timescale 1ns/1ps
module page_match #(
  parameter int ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              set_i,
  input  logic              clr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] page_mask;
  logic [ADDR_W-1:0] page_q;
  logic              vld_q;

  always_comb page_mask = ~((ADDR_W'(1) << (3'd2 + 3'(size_i))) - ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      page_q <= '0;
    end else if (set_i) begin
      vld_q  <= 1'b1;
      page_q <= addr_i & page_mask;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit_o = vld_q && ((addr_i & page_mask) == page_q);

  AST_CLR_CLOSES_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !hit_o); // R7
endmodule

// File: rtl/pulse_timer.sv
`timescale 1ns/1ps
module pulse_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= (val_i == '0) ? CNT_W'(1) : val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q != '0)); // R8
endmodule

// File: rtl/rd_capture.sv
`timescale 1ns/1ps
module rd_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= data_i;
    end
  end

  AST_VALID_FOLLOWS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> rvalid_o); // R6
  AST_VALID_ONLY_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> !rvalid_o); // R6
endmodule

// File: rtl/page_rd_ctrl.sv
`timescale 1ns/1ps
module page_rd_ctrl
  import page_rd_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rdy_o,
  input  logic              page_en_i,
  input  logic [1:0]        page_size_i,
  input  logic [1:0]        dev_width_i,
  input  logic [CNT_W-1:0]  first_pulse_i,
  input  logic [CNT_W-1:0]  next_pulse_i,
  output logic              mem_cs_no,
  output logic              mem_rd_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] lane_mask;
  logic              strobe_nq;
  logic              tmr_last, tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              pm_hit, page_hit;
  logic              in_access, end_access;
  logic              accept_first, accept_next;

  // low address bits that select bytes inside one device word
  always_comb begin
    case (dev_width_i)
      2'd0:    lane_mask = '1;
      2'd1:    lane_mask = ~ADDR_W'(1);
      default: lane_mask = ~ADDR_W'(3);
    endcase
  end

  always_comb begin
    in_access    = (state_q == ST_ACCESS);
    end_access   = in_access && tmr_last;
    page_hit     = page_en_i && pm_hit;
    accept_first = (state_q == ST_IDLE) && req_i;
    accept_next  = end_access && req_i && page_hit;
    rdy_o        = (state_q == ST_IDLE) || (end_access && page_hit);
    tmr_load     = accept_first || accept_next;
    tmr_val      = accept_next ? next_pulse_i : first_pulse_i;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_ACCESS;
      ST_ACCESS: if (tmr_last) state_d = accept_next ? ST_ACCESS : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      strobe_nq <= 1'b1;
      addr_q    <= '0;
    end else begin
      state_q   <= state_d;
      strobe_nq <= (state_d != ST_ACCESS);
      if (tmr_load) addr_q <= addr_i & lane_mask;
    end
  end

  assign mem_cs_no  = strobe_nq;
  assign mem_rd_no  = strobe_nq;
  assign mem_addr_o = addr_q;

  page_match #(.ADDR_W(ADDR_W)) i_page_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (page_size_i),
    .addr_i (addr_i),
    .set_i  (accept_first),
    .clr_i  (end_access && !accept_next),
    .hit_o  (pm_hit)
  );

  pulse_timer #(.CNT_W(CNT_W)) i_pulse_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .last_o (tmr_last)
  );

  rd_capture #(.DATA_W(DATA_W)) i_rd_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (end_access),
    .data_i    (mem_data_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  AST_GAP_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_access && !accept_next) |=> (mem_cs_no && mem_rd_no)); // R7
  AST_BURST_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_next |=> (!mem_cs_no && !mem_rd_no)); // R3
  AST_NO_BURST_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_en_i && in_access) |-> !rdy_o); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_access && !tmr_last) |=> $stable(mem_addr_o)); // R5
  AST_LOW_STARTS_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_first |=> !mem_cs_no); // R2
endmodule

// File: tb/test_page_rd_ctrl.sv
`timescale 1ns/1ps
module test_page_rd_ctrl;
  localparam int AW = 26;
  localparam int DW = 32;
  localparam int CW = 6;
  localparam int LOG_N = 256;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          rdy_o;
  logic          page_en_i = 1'b0;
  logic [1:0]    page_size_i = 2'd0;
  logic [1:0]    dev_width_i = 2'd0;
  logic [CW-1:0] first_pulse_i = 6'd3;
  logic [CW-1:0] next_pulse_i = 6'd1;
  logic          mem_cs_no, mem_rd_no;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_i;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {6'd0, a} ^ 32'h5A5A_0000;
  endfunction

  assign mem_data_i = mem_rd_no ? '0 : mem_word(mem_addr_o);

  page_rd_ctrl i_page_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .rdy_o(rdy_o),
    .page_en_i(page_en_i), .page_size_i(page_size_i), .dev_width_i(dev_width_i),
    .first_pulse_i(first_pulse_i), .next_pulse_i(next_pulse_i),
    .mem_cs_no(mem_cs_no), .mem_rd_no(mem_rd_no), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // per-cycle log
  logic          log_on = 1'b0;
  int            n_log = 0;
  logic          cs_log [LOG_N];
  logic          rd_log [LOG_N];
  logic [AW-1:0] ad_log [LOG_N];
  logic          rv_log [LOG_N];
  logic [DW-1:0] da_log [LOG_N];

  always @(negedge clk) begin
    if (log_on && n_log < LOG_N) begin
      cs_log[n_log] = mem_cs_no;
      rd_log[n_log] = mem_rd_no;
      ad_log[n_log] = mem_addr_o;
      rv_log[n_log] = rvalid_o;
      da_log[n_log] = rdata_o;
      n_log = n_log + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] lane_align(input logic [AW-1:0] a);
    case (dev_width_i)
      2'd0:    return a;
      2'd1:    return a & ~AW'(1);
      default: return a & ~AW'(3);
    endcase
  endfunction

  function automatic int eff(input logic [CW-1:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  logic [AW-1:0] req_addr [8];

  // drives n back-to-back requests and compares the logged trace to the model
  task automatic run_burst(input int n, input string tag);
    logic          e_cs [LOG_N];
    logic [AW-1:0] e_ad [LOG_N];
    logic          e_rv [LOG_N];
    logic [DW-1:0] e_da [LOG_N];
    int idx, len, m_cs, m_rd, m_ad, m_rv, first_bad;
    for (int k = 0; k < LOG_N; k++) begin e_rv[k] = 1'b0; e_da[k] = '0; e_ad[k] = '0; end
    idx = 0;
    e_cs[idx] = 1'b1; idx++;
    for (int i = 0; i < n; i++) begin
      bit hit;
      int l;
      hit = page_en_i && (i > 0) &&
            ((req_addr[i] >> (2 + page_size_i)) == (req_addr[i-1] >> (2 + page_size_i)));
      if (i > 0 && !hit) begin e_cs[idx] = 1'b1; idx++; end
      l = hit ? eff(next_pulse_i) : eff(first_pulse_i);
      for (int k = 0; k < l; k++) begin
        e_cs[idx] = 1'b0; e_ad[idx] = lane_align(req_addr[i]); idx++;
      end
      e_rv[idx] = 1'b1; e_da[idx] = mem_word(lane_align(req_addr[i]));
    end
    e_cs[idx] = 1'b1; idx++;
    e_cs[idx] = 1'b1; idx++;
    len = idx;

    @(posedge clk);
    n_log = 0; log_on = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_i = 1'b1; addr_i = req_addr[i];
      #1;
      while (!rdy_o) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    req_i = 1'b0;
    while (n_log < len) @(posedge clk);
    log_on = 1'b0;

    m_cs = 0; m_rd = 0; m_ad = 0; m_rv = 0; first_bad = -1;
    for (int k = 0; k < len; k++) begin
      if (cs_log[k] !== e_cs[k]) begin m_cs++; if (first_bad < 0) first_bad = k; end
      if (rd_log[k] !== cs_log[k]) m_rd++;
      if (e_cs[k] == 1'b0 && ad_log[k] !== e_ad[k]) m_ad++;
      if (rv_log[k] !== e_rv[k] || (e_rv[k] && da_log[k] !== e_da[k])) m_rv++;
    end
    check(m_cs == 0, tag, $sformatf("strobe trace mismatches (first at cycle %0d)", first_bad), m_cs, 0);
    check(m_rd == 0, "R11", "cycles where cs and rd differ", m_rd, 0);
    check(m_ad == 0, "R5", "address mismatches while strobed", m_ad, 0);
    check(m_rv == 0, "R6", "valid/data mismatches", m_rv, 0);
  endtask

  task automatic t_reset();
    #1;
    check(mem_cs_no === 1'b1, "R10", "cs after reset", mem_cs_no, 1);
    check(mem_rd_no === 1'b1, "R10", "rd after reset", mem_rd_no, 1);
    check(rvalid_o === 1'b0, "R10", "rvalid after reset", rvalid_o, 0);
    check(rdy_o === 1'b1, "R10", "rdy after reset", rdy_o, 1);
  endtask

  task automatic t_burst16();
    page_en_i = 1; page_size_i = 2'd2; dev_width_i = 2'd2;
    first_pulse_i = 6'd5; next_pulse_i = 6'd2;
    req_addr[0] = 26'h100; req_addr[1] = 26'h104; req_addr[2] = 26'h10B;
    req_addr[3] = 26'h10C; req_addr[4] = 26'h110;
    run_burst(5, "R2 R3 R4");
  endtask

  task automatic t_page4_w16();
    page_en_i = 1; page_size_i = 2'd0; dev_width_i = 2'd1;
    first_pulse_i = 6'd3; next_pulse_i = 6'd1;
    req_addr[0] = 26'h201; req_addr[1] = 26'h203; req_addr[2] = 26'h204; req_addr[3] = 26'h206;
    run_burst(4, "R4");
  endtask

  task automatic t_page32_w8();
    page_en_i = 1; page_size_i = 2'd3; dev_width_i = 2'd0;
    first_pulse_i = 6'd4; next_pulse_i = 6'd2;
    req_addr[0] = 26'h401; req_addr[1] = 26'h41F; req_addr[2] = 26'h420; req_addr[3] = 26'h43E;
    run_burst(4, "R4");
  endtask

  task automatic t_page8();
    page_en_i = 1; page_size_i = 2'd1; dev_width_i = 2'd0;
    first_pulse_i = 6'd3; next_pulse_i = 6'd2;
    req_addr[0] = 26'h807; req_addr[1] = 26'h800; req_addr[2] = 26'h808;
    run_burst(3, "R4");
  endtask

  task automatic t_disabled();
    page_en_i = 0; page_size_i = 2'd3; dev_width_i = 2'd2;
    first_pulse_i = 6'd3; next_pulse_i = 6'd1;
    req_addr[0] = 26'h100; req_addr[1] = 26'h104; req_addr[2] = 26'h108;
    run_burst(3, "R1");
  endtask

  task automatic t_zero();
    page_en_i = 1; page_size_i = 2'd2; dev_width_i = 2'd2;
    first_pulse_i = 6'd0; next_pulse_i = 6'd0;
    req_addr[0] = 26'h300; req_addr[1] = 26'h304; req_addr[2] = 26'h308;
    run_burst(3, "R8");
  endtask

  task automatic t_close();
    // same page in two separate bursts: second must be a full first access
    page_en_i = 1; page_size_i = 2'd2; dev_width_i = 2'd2;
    first_pulse_i = 6'd4; next_pulse_i = 6'd1;
    req_addr[0] = 26'h500;
    run_burst(1, "R7");
    req_addr[0] = 26'h504;
    run_burst(1, "R7");
  endtask

  task automatic t_ready();
    page_en_i = 1; page_size_i = 2'd2; dev_width_i = 2'd2;
    first_pulse_i = 6'd4; next_pulse_i = 6'd1;
    @(negedge clk);
    req_i = 1'b1; addr_i = 26'h600;
    #1;
    check(rdy_o === 1'b1, "R9", "rdy while idle", rdy_o, 1);
    @(posedge clk);
    @(negedge clk);
    addr_i = 26'h604;
    #1;
    check(rdy_o === 1'b0, "R9", "rdy mid access on hit", rdy_o, 0);
    @(negedge clk);
    req_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_burst16();
    t_page4_w16();
    t_page32_w8();
    t_page8();
    t_disabled();
    t_zero();
    t_close();
    t_ready();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule